// File: doc/BRIEF.md
# Reshapeable Dual-Port Memory

This block holds 1,152 bits of storage behind one write port and one read port. Each port has its own clock and both may be used in the same cycle. A two-bit shape input picks, at run time, how the bits are grouped into words: eighteen bits wide and 64 deep, nine wide and 128 deep, four wide and 256 deep, or two wide and 512 deep. The address and data buses always have their full widths (9 and 18 bits). A narrow shape uses only the low data lanes and as many address bits as its depth needs.

The read side has two behaviours, chosen by a level input that is meant to stay fixed for a given use. In clocked mode an output register loads the addressed word on a read-clock edge when the read enable is high, and holds its value otherwise. In flow-through mode the output follows the read address with no clock.

The storage is one flat bit array. Word N of a shape that is W bits wide sits at bit positions N*W through N*W+W-1. A word written in one shape can therefore be read back in another shape as a set of slices.

Top module: `ratio_dpram`

## Requirements
- R1: The shape code picks the word layout: 0 gives 64 words of 18 bits, 1 gives 128 of 9, 2 gives 256 of 4, and 3 gives 512 of 2. A word written in any shape reads back with all of its lanes intact.
- R2: A word is stored only on a rising write-clock edge where wr_en is high. When wr_en is low the stored contents do not change.
- R3: Data lanes at or above the shape width are ignored on write. The same upper lanes of rd_data always read as zero.
- R4: Address bits above those the shape depth needs are ignored. In 128x9, for example, address A and address A+128 select the same word.
- R5: In clocked mode, a rising read-clock edge with rd_en high loads rd_data with the word at rd_addr as it stood just before that edge.
- R6: In clocked mode, rd_data holds its value through every edge where rd_en is low, even if rd_addr changes.
- R7: A synchronous active-low reset on the read clock clears the rd_data register to zero.
- R8: When async_rd is high, rd_data shows the word at rd_addr combinationally and follows address changes with no clock edge.
- R9: When the write and read addresses match on the same edge: in clocked mode the read returns the previous contents and the next enabled read returns the new word; in flow-through mode the new word appears on rd_data right after the write edge.
- R10: Word N of a W-bit shape occupies array bits N*W to N*W+W-1. So an 18-bit word written at address 7 in shape 0 reads back as 2-bit words 63 to 71 in shape 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock; writes happen on its rising edge |
| rclk | input | 1 | Read clock; drives the output register and reset |
| rst_n | input | 1 | Active-low reset, synchronous to rclk |
| shape | input | 2 | Word layout code (0..3, see R1) |
| async_rd | input | 1 | 1 selects flow-through read, 0 selects clocked read |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 9 | Write word address |
| wr_data | input | 18 | Write data; only the low shape-width lanes are used |
| rd_en | input | 1 | Read enable for clocked mode |
| rd_addr | input | 9 | Read word address |
| rd_data | output | 18 | Read data; lanes above the shape width are zero |

## Verification
Some behaviours are checked on every cycle by the bound checker. These are: the output register loads on an enabled clocked read and holds when the read is idle, the output is cleared after reset, the upper lanes read as zero, and a flow-through read shows a matching write after the write edge. Other behaviours only the bench scenarios can show, because they need a reference image of the whole array. These are: address wrap, writes blocked by wr_en, words written in one shape and read as slices in another, and the old/new ordering of a same-address collision in clocked mode. The bench checks all of these against a bit-level model, using seeded random traffic in every shape and both read modes together with directed cases.

// File: rtl/ratio_ram_pkg.sv
// Shared types and helpers for the reshapeable dual-port memory.
// Assumes shape code k halves the word width k times (integer shift) and
// doubles the depth k times, starting from the widest layout.
package ratio_ram_pkg;

    localparam int NSHAPE = 4;

    typedef enum logic [1:0] {
        SHP_W18 = 2'd0,
        SHP_W9  = 2'd1,
        SHP_W4  = 2'd2,
        SHP_W2  = 2'd3
    } shape_t;

    // Number of active data lanes for a shape.
    function automatic int lanes_of(input shape_t s, input int data_w);
        return data_w >> int'(s);
    endfunction

    // Number of words for a shape, given the full address width.
    function automatic int depth_of(input shape_t s, input int addr_w);
        return (1 << addr_w) >> (NSHAPE - 1 - int'(s));
    endfunction

endpackage

// File: rtl/rr_addr_map.sv
// Converts a word address and a shape into the first bit position and the lane
// count inside the flat array. Address bits above the shape depth are dropped.
// Purely combinational. Assumes BIT_AW can hold the largest base plus width.
module rr_addr_map
    import ratio_ram_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 18,
    parameter int BIT_AW = 11,
    parameter int LANE_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  shape_t            shape,
    output logic [BIT_AW-1:0] base,
    output logic [LANE_W-1:0] lanes
);

    logic [ADDR_W-1:0] masked;
    int                n_lanes;

    // Mask the address to the shape depth and scale it by the word width.
    always_comb begin
        n_lanes = lanes_of(shape, DATA_W);
        masked  = addr & ADDR_W'(depth_of(shape, ADDR_W) - 1);
        lanes   = LANE_W'(n_lanes);
        base    = BIT_AW'(int'(masked) * n_lanes);
    end

endmodule

// File: rtl/rr_store.sv
// Flat bit array with one write port and one combinational read slice.
// A write updates lanes [0, wlanes) at wbase on the rising wclk edge when we
// is high. The read slice returns lanes [0, rlanes) from rbase with zeros
// above. Contents are not reset. Assumes base + lanes never exceeds BITS.
module rr_store #(
    parameter int DATA_W = 18,
    parameter int BITS   = 1152,
    parameter int BIT_AW = 11,
    parameter int LANE_W = 5
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [BIT_AW-1:0] wbase,
    input  logic [LANE_W-1:0] wlanes,
    input  logic [DATA_W-1:0] wd,
    input  logic [BIT_AW-1:0] rbase,
    input  logic [LANE_W-1:0] rlanes,
    output logic [DATA_W-1:0] rword
);

    logic [BITS-1:0] mem;

    // Store the active lanes of the write word into the array.
    always_ff @(posedge wclk) begin
        for (int i = 0; i < DATA_W; i++) begin
            if (we && (i < int'(wlanes))) begin
                mem[wbase + BIT_AW'(i)] <= wd[i];
            end
        end
    end

    // One read multiplexer per lane; lanes beyond the shape width read zero.
    for (genvar g = 0; g < DATA_W; g++) begin : g_rd_lane
        assign rword[g] = (g < int'(rlanes)) ? mem[rbase + BIT_AW'(g)] : 1'b0;
    end

endmodule

// File: rtl/rr_read_port.sv
// Output stage of the read side: a register loaded on rclk when re is high,
// or a direct path from the array when async_rd is high.
// The register resets synchronously to zero. Assumes async_rd is quasi-static.
module rr_read_port #(
    parameter int DATA_W = 18
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              async_rd,
    input  logic              re,
    input  logic [DATA_W-1:0] rword,
    output logic [DATA_W-1:0] rd
);

    logic [DATA_W-1:0] rd_q;

    // Capture the addressed word on an enabled read edge; otherwise hold it.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (re) begin
            rd_q <= rword;
        end
    end

    // Choose between the flow-through word and the registered word.
    always_comb begin
        rd = async_rd ? rword : rd_q;
    end

endmodule

// File: rtl/ratio_dpram.sv
// Top level of the reshapeable 1,152-bit dual-port memory. It places one
// address map per port, the shared bit array, and the read output stage.
// Assumes shape is changed only while neither port is active.
module ratio_dpram
    import ratio_ram_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 18
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [1:0]        shape,
    input  logic              async_rd,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int BITS   = DATA_W * ((1 << ADDR_W) >> (NSHAPE - 1));
    localparam int BIT_AW = $clog2(BITS);
    localparam int LANE_W = $clog2(DATA_W + 1);

    shape_t            shp;
    logic [BIT_AW-1:0] w_base;
    logic [BIT_AW-1:0] r_base;
    logic [LANE_W-1:0] w_lanes;
    logic [LANE_W-1:0] r_lanes;
    logic [DATA_W-1:0] rd_word;

    // Interpret the raw shape pins as the shape type.
    always_comb begin
        shp = shape_t'(shape);
    end

    rr_addr_map #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_AW(BIT_AW), .LANE_W(LANE_W)
    ) u_wmap (
        .addr(wr_addr), .shape(shp), .base(w_base), .lanes(w_lanes)
    );

    rr_addr_map #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_AW(BIT_AW), .LANE_W(LANE_W)
    ) u_rmap (
        .addr(rd_addr), .shape(shp), .base(r_base), .lanes(r_lanes)
    );

    rr_store #(
        .DATA_W(DATA_W), .BITS(BITS), .BIT_AW(BIT_AW), .LANE_W(LANE_W)
    ) u_store (
        .wclk(wclk), .we(wr_en), .wbase(w_base), .wlanes(w_lanes), .wd(wr_data),
        .rbase(r_base), .rlanes(r_lanes), .rword(rd_word)
    );

    rr_read_port #(
        .DATA_W(DATA_W)
    ) u_rport (
        .rclk(rclk), .rst_n(rst_n), .async_rd(async_rd), .re(rd_en),
        .rword(rd_word), .rd(rd_data)
    );

endmodule

// File: rtl/ratio_dpram_chk.sv
// Property checker for ratio_dpram, attached with bind. It watches the ports
// and the array read slice. Assumes wclk and rclk are the same clock when the
// flow-through write-visibility property is relied upon.
module ratio_dpram_chk #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 18
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst_n,
    input logic [1:0]        shape,
    input logic              async_rd,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] lane_mask;

    // Mask of the lanes the current shape uses.
    always_comb begin
        lane_mask = DATA_W'((64'd1 << (DATA_W >> shape)) - 64'd1);
    end

    AST_RESET_CLEARS: assert property (@(posedge rclk) disable iff (!rst_n)
        (!async_rd && $past(!rst_n)) |-> (rd_data == '0)); // R7

    AST_LOAD_ON_READ: assert property (@(posedge rclk) disable iff (!rst_n)
        (!async_rd && $past(!async_rd) && $past(rd_en) && $past(rst_n))
        |-> (rd_data == $past(rd_word))); // R5

    AST_HOLD_IDLE: assert property (@(posedge rclk) disable iff (!rst_n)
        (!async_rd && $past(!async_rd) && !$past(rd_en) && $past(rst_n))
        |-> $stable(rd_data)); // R6

    AST_UPPER_ZERO: assert property (@(posedge rclk) disable iff (!rst_n)
        (async_rd || ($past(rd_en) && $stable(shape) && $past(!async_rd) && $past(rst_n)))
        |-> ((rd_data & ~lane_mask) == '0)); // R3

    AST_FLOW_SEES_WRITE: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && async_rd && (wr_addr == rd_addr))
        |=> (!async_rd || !$stable(rd_addr) || !$stable(shape)
             || ((rd_data & lane_mask) == ($past(wr_data) & lane_mask)))); // R9

endmodule

bind ratio_dpram ratio_dpram_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .shape(shape), .async_rd(async_rd),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_word(rd_word)
);

// File: tb/test_ratio_dpram.sv
// Self-checking bench for ratio_dpram: seeded random traffic in every shape
// and both read modes, plus directed corner cases, against a bit-level model.
module test_ratio_dpram;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 9;
    localparam int DW = 18;
    localparam int NB = 1152;

    logic          clk;
    logic          rst_n;
    logic [1:0]    shape;
    logic          async_rd;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;

    logic [NB-1:0] ref_mem;
    logic [DW-1:0] exp_q;
    int            checks;
    int            failures;

    ratio_dpram #(.ADDR_W(AW), .DATA_W(DW)) i_ratio_dpram (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .shape(shape), .async_rd(async_rd),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    // Word read from the model image under the current shape.
    function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
        int w;
        int base;
        logic [DW-1:0] r;
        w    = DW >> shape;
        base = int'(a & AW'(((1 << AW) >> (3 - shape)) - 1)) * w;
        r    = '0;
        for (int i = 0; i < w; i++) r[i] = ref_mem[base + i];
        return r;
    endfunction

    // Word write into the model image under the current shape.
    task automatic model_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int w;
        int base;
        w    = DW >> shape;
        base = int'(a & AW'(((1 << AW) >> (3 - shape)) - 1)) * w;
        for (int i = 0; i < w; i++) ref_mem[base + i] = d[i];
    endtask

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clocked-mode cycle, entered and left at a falling edge.
    task automatic sync_cycle(input bit we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                              input bit re, input logic [AW-1:0] ra, input string req);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        if (re) exp_q = model_rd(ra);
        if (we) model_wr(wa, wd);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(req, rd_data, exp_q);
    endtask

    // One flow-through cycle: check before the write edge, then clock it.
    task automatic async_cycle(input bit we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                               input logic [AW-1:0] ra, input string req);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = 1'b0; rd_addr = ra;
        #1;
        check(req, rd_data, model_rd(ra));
        if (we) model_wr(wa, wd);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        checks = 0; failures = 0;
        ref_mem = '0; exp_q = '0;
        void'($urandom(32'h5EED_0C3A));
        rst_n = 1'b0; shape = 2'd0; async_rd = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_en = 1'b0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R7 reset clears output", rd_data, 18'h0);
        @(posedge clk); @(negedge clk);
        check("R7 output stays clear", rd_data, 18'h0);

        // Fill the whole array in the widest shape so the model is fully defined.
        for (int a = 0; a < 64; a++) sync_cycle(1'b1, AW'(a), DW'($urandom), 1'b0, '0, "R1 fill");
        for (int a = 0; a < 64; a++) sync_cycle(1'b0, '0, '0, 1'b1, AW'(a), "R1 fill readback");

        // Random clocked traffic in every shape: full-width addresses and data.
        for (int s = 0; s < 4; s++) begin
            shape = 2'(s);
            for (int n = 0; n < 250; n++) begin
                sync_cycle(1'($urandom), AW'($urandom), DW'($urandom), 1'($urandom),
                           AW'($urandom), "R5/R6 clocked random");
            end
        end

        // R4: wrap within the selected depth.
        shape = 2'd1;
        sync_cycle(1'b1, 9'd5, 18'h3FE5A, 1'b0, '0, "R4 setup");
        sync_cycle(1'b0, '0, '0, 1'b1, 9'd133, "R4 wrap read");
        check("R4 wrap literal", rd_data, 18'h05A);

        // R3: upper data lanes ignored on write and zero on read.
        shape = 2'd2;
        sync_cycle(1'b1, 9'd200, 18'h3FFF5, 1'b0, '0, "R3 setup");
        sync_cycle(1'b0, '0, '0, 1'b1, 9'd200, "R3 upper lanes");
        check("R3 literal", rd_data, 18'h00005);

        // R2: write with wr_en low leaves the word unchanged.
        sync_cycle(1'b0, 9'd200, 18'h3FFFA, 1'b0, '0, "R2 blocked write");
        sync_cycle(1'b0, '0, '0, 1'b1, 9'd200, "R2 readback");
        check("R2 literal", rd_data, 18'h00005);

        // R6: output holds while rd_en is low and the address moves.
        for (int n = 0; n < 4; n++) begin
            sync_cycle(1'b0, '0, '0, 1'b0, AW'(n * 37), "R6 hold");
            check("R6 hold literal", rd_data, 18'h00005);
        end

        // R10: an 18-bit word seen as nine 2-bit words.
        shape = 2'd0;
        sync_cycle(1'b1, 9'd7, 18'h2B3C6, 1'b0, '0, "R10 setup");
        shape = 2'd3;
        sync_cycle(1'b0, '0, '0, 1'b1, 9'd63, "R10 slice 0");
        check("R10 slice 0 literal", rd_data, 18'h2);
        sync_cycle(1'b0, '0, '0, 1'b1, 9'd64, "R10 slice 1");
        check("R10 slice 1 literal", rd_data, 18'h1);
        sync_cycle(1'b0, '0, '0, 1'b1, 9'd71, "R10 slice 8");
        check("R10 slice 8 literal", rd_data, 18'h2);

        // R9 clocked: same-edge collision returns old, next read returns new.
        shape = 2'd1;
        sync_cycle(1'b1, 9'd20, 18'h1F0, 1'b0, '0, "R9 setup");
        sync_cycle(1'b1, 9'd20, 18'h0AB, 1'b1, 9'd20, "R9 clocked old");
        check("R9 clocked old literal", rd_data, 18'h1F0);
        sync_cycle(1'b0, '0, '0, 1'b1, 9'd20, "R9 clocked new");
        check("R9 clocked new literal", rd_data, 18'h0AB);

        // Flow-through mode.
        async_rd = 1'b1;
        // R8: output follows the address with no clock edge.
        for (int n = 0; n < 6; n++) begin
            rd_addr = AW'($urandom);
            #1;
            check("R8 flow-through follow", rd_data, model_rd(rd_addr));
        end
        // R9 flow-through: new word visible right after the write edge.
        wr_en = 1'b1; wr_addr = 9'd30; wr_data = 18'h155; rd_addr = 9'd30;
        #1;
        check("R9 flow-through before edge", rd_data, model_rd(9'd30));
        model_wr(9'd30, 18'h155);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        check("R9 flow-through after edge", rd_data, 18'h155);

        for (int s = 0; s < 4; s++) begin
            shape = 2'(s);
            for (int n = 0; n < 150; n++) begin
                async_cycle(1'($urandom), AW'($urandom), DW'($urandom), AW'($urandom),
                            "R8 flow-through random");
            end
            async_cycle(1'b1, 9'd3, 18'h3ABCD, 9'd3, "R9 flow-through random collision");
            #1;
            check("R9 flow-through collision after", rd_data, model_rd(9'd3));
        end

        // R1: a full word per shape reads back intact in clocked mode.
        async_rd = 1'b0;
        for (int s = 0; s < 4; s++) begin
            shape = 2'(s);
            sync_cycle(1'b1, 9'd9, 18'h3FFFF, 1'b0, '0, "R1 setup");
            sync_cycle(1'b0, '0, '0, 1'b1, 9'd9, "R1 full word");
            check("R1 full word literal", rd_data, DW'((1 << (DW >> s)) - 1));
        end

        finish_run();
    end

endmodule